// File: doc/BRIEF.md
# Match and Capture Timer

This block is a 32-bit timer/counter with a byte-addressed register interface on a simple memory-mapped bus. A prescaler divides the count source. The counter then advances once for every prescale period. Four match channels compare against the counter. On a match, each channel can flag an interrupt, restart the counter, halt counting, and set, clear or toggle its own match output pin. Four capture channels watch their input pins through a synchronizer. On a chosen edge, a capture channel records the counter value and can flag an interrupt.

The count source is selectable. It is either every clock cycle or the edges of one of the capture pins. A single interrupt line stays high while any flag is pending. Software clears a flag by writing a one to its bit.

Reads are combinational from `busAddr` and do not depend on `busSel`. Writes take effect at the clock edge where `busSel` and `busWrite` are both high.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `matchOut` is 0000.
- R2: Byte offsets are as follows: flags 0x00, control 0x04, counter 0x08, prescale 0x0C, prescale counter 0x10, match control 0x14, match values at 0x18 + 4n, capture control 0x28, capture values at 0x2C + 4n, match-output control 0x3C and count source 0x70. Writable registers read back what was written. Any unmapped offset reads as zero.
- R3: In the control register, bit 0 enables counting. While bit 1 is set, the counter and the prescale counter are held at zero and nothing advances.
- R4: The prescale counter steps on each count event. When it equals the prescale value it returns to 0 and the counter increments, so one count takes prescale+1 events. With counting disabled, the counter holds its value.
- R5: A match on channel n occurs at the count event that would take the counter to match value n. Match control bit 3n sets flag n. Bit 3n+1 loads 0 into the counter instead of the match value. Bit 3n+2 clears the enable bit. With prescale 0 and match value N, with flag and restart enabled, a flag is raised every N clocks.
- R6: On a match, match output n follows the 2-bit code at bits 4+2n of register 0x3C: 0 keeps it, 1 drives it low, 2 drives it high, 3 inverts it. Bits 3:0 of that register hold the outputs and can be written.
- R7: Capture pins pass through a two-flop synchronizer. In capture control, bit 3n arms capture on a rising edge of pin n and bit 3n+1 arms it on a falling edge. On an armed edge, capture register n loads the counter value of the detection cycle, and flag 4+n is set when bit 3n+2 is set.
- R8: Flags are write-one-to-clear. A hardware set in the same cycle as a clear keeps the flag set. `irq` is high while any flag is set.
- R9: Bits 1:0 of register 0x70 select the count source: 0 is every clock, 1 is rising edges, 2 is falling edges and 3 is both edges. Bits 3:2 select which capture pin is used.
- R10: Writes to the capture value registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | High for a write access |
| busAddr | input | 7 | Byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| capPin | input | 4 | Capture / count input pins |
| matchOut | output | 4 | Match output pins |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims at the match boundary, where a design that restarts one count too late would stretch the period to N+1 clocks. It also aims at a stop event, which must leave the counter sitting exactly on the match value with enable cleared. A software clear is hammered every cycle against a periodic match: a design that let the clear win would lose flags and keep `irq` low. Edge-counting mode and capture latching are run against pin pulses of known length, where a missing or extra synchronizer stage shows up as a wrong captured value or an extra count.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 7;
  localparam int SRC_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_FLAGS  = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_PSC    = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_PSCCNT = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_MCTL   = 7'h14;
  localparam logic [ADDR_W-1:0] OFS_MVAL0  = 7'h18;
  localparam logic [ADDR_W-1:0] OFS_CCTL   = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_CVAL0  = 7'h2C;
  localparam logic [ADDR_W-1:0] OFS_EXT    = 7'h3C;
  localparam logic [ADDR_W-1:0] OFS_SRC    = 7'h70;

  typedef enum logic [1:0] {EXT_KEEP = 2'd0, EXT_LOW = 2'd1, EXT_HIGH = 2'd2, EXT_FLIP = 2'd3} extAct_e;
  typedef enum logic [1:0] {SRC_CLK = 2'd0, SRC_RISE = 2'd1, SRC_FALL = 2'd2, SRC_BOTH = 2'd3} cntSrc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              holdClr;
    logic              advance;
    logic              wrCount;
    logic              wrPsc;
    logic [NUM_CH-1:0] capLoad;
  } tmrStrobe_t;

  function automatic logic [ADDR_W-1:0] matchOfs(input int n);
    return OFS_MVAL0 + ADDR_W'(4 * n);
  endfunction

  function automatic logic [ADDR_W-1:0] capOfs(input int n);
    return OFS_CVAL0 + ADDR_W'(4 * n);
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  output logic [NUM_CH-1:0] riseDet,
  output logic [NUM_CH-1:0] fallDet
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
    logic meta, stable, prior;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b0;
        stable <= 1'b0;
        prior  <= 1'b0;
      end else begin
        meta   <= pinIn[ch];
        stable <= meta;
        prior  <= stable;
      end
    end
    assign riseDet[ch] = stable & ~prior;
    assign fallDet[ch] = ~stable & prior;
  end
endmodule

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tmrStrobe_t                    strb,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [CNT_W-1:0]              prescale,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  matchVal,
  input  logic [NUM_CH-1:0]             resetEn,
  output logic [CNT_W-1:0]              count,
  output logic [CNT_W-1:0]              pscCnt,
  output logic [NUM_CH-1:0][CNT_W-1:0]  capVal,
  output logic [NUM_CH-1:0]             matchEvt
);
  logic             tick;
  logic [CNT_W-1:0] nextCnt;
  logic             anyReset;

  assign tick     = strb.advance && (pscCnt == prescale);
  assign nextCnt  = count + CNT_W'(1);
  assign anyReset = |(matchEvt & resetEn);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_match
    assign matchEvt[ch] = tick && (nextCnt == matchVal[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.holdClr) begin
      count <= '0;
    end else if (strb.wrCount) begin
      count <= wrData;
    end else if (tick) begin
      count <= anyReset ? '0 : nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (strb.holdClr) begin
      pscCnt <= '0;
    end else if (strb.wrPsc) begin
      pscCnt <= wrData;
    end else if (strb.advance) begin
      pscCnt <= tick ? '0 : pscCnt + CNT_W'(1);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cap
    logic [CNT_W-1:0] capReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) capReg <= '0;
      else if (strb.capLoad[ch]) capReg <= count;
    end
    assign capVal[ch] = capReg;

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      strb.capLoad[ch] |=> capVal[ch] == $past(count)) else $error("capture latch"); // R7
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdClr |=> (count == '0) && (pscCnt == '0)) else $error("hold clear"); // R3
  AST_MATCH_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (anyReset && !strb.holdClr && !strb.wrCount) |=> count == '0) else $error("match reset"); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.holdClr && !strb.wrCount) |=> $stable(count)) else $error("idle"); // R4
endmodule

// File: rtl/tmr_control.sv
`timescale 1ns/1ps
module tmr_control
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [CNT_W-1:0]              busWrData,
  output logic [CNT_W-1:0]              busRdData,
  input  logic [NUM_CH-1:0]             capPin,
  input  logic [NUM_CH-1:0]             matchEvt,
  input  logic [CNT_W-1:0]              count,
  input  logic [CNT_W-1:0]              pscCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  capVal,
  output tmrStrobe_t                    strb,
  output logic [CNT_W-1:0]              prescale,
  output logic [NUM_CH-1:0][CNT_W-1:0]  matchVal,
  output logic [NUM_CH-1:0]             resetEn,
  output logic [NUM_CH-1:0]             matchOut,
  output logic                          irqOut
);
  localparam int FLAG_W = 2 * NUM_CH;
  localparam int CTL_W  = 3 * NUM_CH;
  localparam int SEL_W  = $clog2(NUM_CH);

  logic [FLAG_W-1:0]   flags;
  logic                enable, hold;
  logic [CTL_W-1:0]    matchCtl, capCtl;
  logic [NUM_CH-1:0]   extState;
  logic [FLAG_W-1:0]   extCtl;
  logic [SRC_W-1:0]    srcSel;

  logic                wrEn;
  logic [NUM_CH-1:0]   riseDet, fallDet;
  logic [NUM_CH-1:0]   matchIntEn, stopEn, capIntEn, capEvt;
  logic [FLAG_W-1:0]   flagSet;
  logic                srcEvent, anyStop;
  logic [NUM_CH-1:0]   extNext;
  logic [SEL_W-1:0]    pinSel;

  assign wrEn = busSel && busWrite;

  tmr_edge_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(capPin), .riseDet(riseDet), .fallDet(fallDet)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ctl
    assign matchIntEn[ch] = matchCtl[3*ch];
    assign resetEn[ch]    = matchCtl[3*ch+1];
    assign stopEn[ch]     = matchCtl[3*ch+2];
    assign capIntEn[ch]   = capCtl[3*ch+2];
    assign capEvt[ch]     = (riseDet[ch] & capCtl[3*ch]) | (fallDet[ch] & capCtl[3*ch+1]);

    logic [CNT_W-1:0] mvReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mvReg <= '0;
      else if (wrEn && busAddr == matchOfs(ch)) mvReg <= busWrData;
    end
    assign matchVal[ch] = mvReg;
  end

  assign flagSet = {capEvt & capIntEn, matchEvt & matchIntEn};
  assign anyStop = |(matchEvt & stopEn);
  assign pinSel  = srcSel[2 +: SEL_W];

  always_comb begin
    unique case (cntSrc_e'(srcSel[1:0]))
      SRC_CLK:  srcEvent = 1'b1;
      SRC_RISE: srcEvent = riseDet[pinSel];
      SRC_FALL: srcEvent = fallDet[pinSel];
      SRC_BOTH: srcEvent = riseDet[pinSel] | fallDet[pinSel];
      default:  srcEvent = 1'b0;
    endcase
  end

  always_comb begin
    strb.holdClr = hold;
    strb.advance = enable && !hold && srcEvent;
    strb.wrCount = wrEn && busAddr == OFS_COUNT;
    strb.wrPsc   = wrEn && busAddr == OFS_PSCCNT;
    strb.capLoad = capEvt;
  end

  always_comb begin
    extNext = (wrEn && busAddr == OFS_EXT) ? busWrData[NUM_CH-1:0] : extState;
    for (int n = 0; n < NUM_CH; n++) begin
      if (matchEvt[n]) begin
        unique case (extAct_e'(extCtl[2*n +: 2]))
          EXT_LOW:  extNext[n] = 1'b0;
          EXT_HIGH: extNext[n] = 1'b1;
          EXT_FLIP: extNext[n] = ~extNext[n];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags    <= '0;
      enable   <= 1'b0;
      hold     <= 1'b0;
      prescale <= '0;
      matchCtl <= '0;
      capCtl   <= '0;
      extState <= '0;
      extCtl   <= '0;
      srcSel   <= '0;
    end else begin
      flags    <= (flags & ~((wrEn && busAddr == OFS_FLAGS) ? busWrData[FLAG_W-1:0] : '0)) | flagSet;
      enable   <= ((wrEn && busAddr == OFS_CTRL) ? busWrData[0] : enable) & ~anyStop;
      if (wrEn && busAddr == OFS_CTRL) hold <= busWrData[1];
      if (wrEn && busAddr == OFS_PSC)  prescale <= busWrData;
      if (wrEn && busAddr == OFS_MCTL) matchCtl <= busWrData[CTL_W-1:0];
      if (wrEn && busAddr == OFS_CCTL) capCtl <= busWrData[CTL_W-1:0];
      if (wrEn && busAddr == OFS_EXT)  extCtl <= busWrData[NUM_CH +: FLAG_W];
      if (wrEn && busAddr == OFS_SRC)  srcSel <= busWrData[SRC_W-1:0];
      extState <= extNext;
    end
  end

  assign matchOut = extState;
  assign irqOut   = |flags;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_FLAGS:  busRdData[FLAG_W-1:0] = flags;
      OFS_CTRL:   busRdData[1:0] = {hold, enable};
      OFS_COUNT:  busRdData = count;
      OFS_PSC:    busRdData = prescale;
      OFS_PSCCNT: busRdData = pscCnt;
      OFS_MCTL:   busRdData[CTL_W-1:0] = matchCtl;
      OFS_CCTL:   busRdData[CTL_W-1:0] = capCtl;
      OFS_EXT:    busRdData[CTL_W-1:0] = {extCtl, extState};
      OFS_SRC:    busRdData[SRC_W-1:0] = srcSel;
      default:    ;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == matchOfs(n)) busRdData = matchVal[n];
      if (busAddr == capOfs(n))   busRdData = capVal[n];
    end
  end

  AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    anyStop |=> !enable) else $error("stop"); // R5
  AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (|flagSet) |=> irqOut) else $error("flag set"); // R8
endmodule

// File: rtl/tmr_match_capture.sv
`timescale 1ns/1ps
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [CNT_W-1:0]      busWrData,
  output logic [CNT_W-1:0]      busRdData,
  input  logic [NUM_CH-1:0]     capPin,
  output logic [NUM_CH-1:0]     matchOut,
  output logic                  irq
);
  tmrStrobe_t                    strb;
  logic [CNT_W-1:0]              prescale, count, pscCnt;
  logic [NUM_CH-1:0][CNT_W-1:0]  matchVal, capVal;
  logic [NUM_CH-1:0]             resetEn, matchEvt;

  tmr_control #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .capPin(capPin), .matchEvt(matchEvt),
    .count(count), .pscCnt(pscCnt), .capVal(capVal), .strb(strb), .prescale(prescale),
    .matchVal(matchVal), .resetEn(resetEn), .matchOut(matchOut), .irqOut(irq)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .prescale(prescale),
    .matchVal(matchVal), .resetEn(resetEn), .count(count), .pscCnt(pscCnt),
    .capVal(capVal), .matchEvt(matchEvt)
  );
endmodule

// File: tb/tmr_match_capture_bench.sv
`timescale 1ns/1ps
module tmr_match_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  capPin = '0;
  logic [3:0]  matchOut;
  logic        irq;

  int checks = 0, errors = 0, cyc = 0;
  bit lockOn = 1'b0;

  always #10 clk = ~clk;

  tmr_match_capture u_tmr_match_capture (
    .clk(clk), .rstN(rstN), .busSel(sel), .busWrite(wr), .busAddr(addr),
    .busWrData(wdata), .busRdData(rdata), .capPin(capPin), .matchOut(matchOut), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mFlags;
  logic        mEn, mHold;
  logic [31:0] mCnt, mPr, mPc;
  logic [11:0] mMcr, mCcr;
  logic [31:0] mMr [4];
  logic [31:0] mCap [4];
  logic [3:0]  mEm;
  logic [7:0]  mEmc;
  logic [3:0]  mCtc;
  logic [3:0]  ms1, ms2, mpv;
  logic [3:0]  nRise, nFall, nEv;
  logic [7:0]  nSet;
  logic [31:0] nNv;
  logic [3:0]  nBase;
  logic        nSrc, nAdv, nTick, nRst, nStop, nWr;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mFlags = 0; mEn = 0; mHold = 0; mCnt = 0; mPr = 0; mPc = 0; mMcr = 0; mCcr = 0;
      for (int i = 0; i < 4; i++) begin mMr[i] = 0; mCap[i] = 0; end
      mEm = 0; mEmc = 0; mCtc = 0; ms1 = 0; ms2 = 0; mpv = 0;
    end else begin
      nWr = sel && wr;
      nRise = ms2 & ~mpv;
      nFall = ~ms2 & mpv;
      case (mCtc[1:0])
        2'd0: nSrc = 1;
        2'd1: nSrc = nRise[mCtc[3:2]];
        2'd2: nSrc = nFall[mCtc[3:2]];
        default: nSrc = nRise[mCtc[3:2]] | nFall[mCtc[3:2]];
      endcase
      nAdv = mEn && !mHold && nSrc;
      nTick = nAdv && (mPc == mPr);
      nNv = mCnt + 1;
      nRst = 0; nStop = 0; nSet = 0;
      for (int n = 0; n < 4; n++) begin
        nEv[n] = nTick && (nNv == mMr[n]);
        if (nEv[n]) begin
          if (mMcr[3*n]) nSet[n] = 1;
          if (mMcr[3*n+1]) nRst = 1;
          if (mMcr[3*n+2]) nStop = 1;
        end
        if ((nRise[n] && mCcr[3*n]) || (nFall[n] && mCcr[3*n+1])) begin
          mCap[n] = mCnt;
          if (mCcr[3*n+2]) nSet[4+n] = 1;
        end
      end
      if (mHold) mCnt = 0;
      else if (nWr && addr == 7'h08) mCnt = wdata;
      else if (nTick) mCnt = nRst ? 0 : nNv;
      if (mHold) mPc = 0;
      else if (nWr && addr == 7'h10) mPc = wdata;
      else if (nAdv) mPc = nTick ? 0 : mPc + 1;
      mFlags = (mFlags & ~((nWr && addr == 7'h00) ? wdata[7:0] : 8'h0)) | nSet;
      nBase = (nWr && addr == 7'h3C) ? wdata[3:0] : mEm;
      for (int n = 0; n < 4; n++)
        if (nEv[n])
          case (mEmc[2*n +: 2])
            2'd1: nBase[n] = 0;
            2'd2: nBase[n] = 1;
            2'd3: nBase[n] = ~nBase[n];
            default: ;
          endcase
      mEm = nBase;
      if (nWr && addr == 7'h3C) mEmc = wdata[11:4];
      if (nWr && addr == 7'h04) begin mEn = wdata[0]; mHold = wdata[1]; end
      if (nStop) mEn = 0;
      if (nWr && addr == 7'h0C) mPr = wdata;
      if (nWr && addr == 7'h14) mMcr = wdata[11:0];
      if (nWr && addr == 7'h28) mCcr = wdata[11:0];
      if (nWr && addr == 7'h70) mCtc = wdata[3:0];
      for (int n = 0; n < 4; n++)
        if (nWr && addr == 7'(8'h18 + 4*n)) mMr[n] = wdata;
      mpv = ms2; ms2 = ms1; ms1 = capPin;
    end
  end

  function automatic logic [31:0] mRead(input logic [6:0] a);
    case (a)
      7'h00: return {24'h0, mFlags};
      7'h04: return {30'h0, mHold, mEn};
      7'h08: return mCnt;
      7'h0C: return mPr;
      7'h10: return mPc;
      7'h14: return {20'h0, mMcr};
      7'h18: return mMr[0];
      7'h1C: return mMr[1];
      7'h20: return mMr[2];
      7'h24: return mMr[3];
      7'h28: return {20'h0, mCcr};
      7'h2C: return mCap[0];
      7'h30: return mCap[1];
      7'h34: return mCap[2];
      7'h38: return mCap[3];
      7'h3C: return {20'h0, mEmc, mEm};
      7'h70: return {28'h0, mCtc};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [6:0] a);
    if (a == 7'h00) return "R8";
    if (a == 7'h04) return "R3";
    if (a == 7'h08 || a == 7'h0C || a == 7'h10) return "R4";
    if (a >= 7'h14 && a <= 7'h24) return "R5";
    if (a >= 7'h28 && a <= 7'h38) return "R7";
    if (a == 7'h3C) return "R6";
    if (a == 7'h70) return "R9";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // lockstep comparison, away from the active edge
  always begin
    @(negedge clk);
    #5;
    if (lockOn) begin
      chk(irq == (mFlags != 0), "R8", "irq vs model", {31'h0, irq}, {31'h0, mFlags != 0});
      chk(matchOut == mEm, "R6", "matchOut vs model", {28'h0, matchOut}, {28'h0, mEm});
      chk(rdata == mRead(addr), tagFor(addr), "read vs model", rdata, mRead(addr));
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R1 watchdog: cycles=%0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic busWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic busRd(input logic [6:0] a, output logic [31:0] d);
    addr = a;
    #2;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int t0, t1, highs;
    idle(4);
    rstN = 1;
    lockOn = 1;
    idle(1);

    // R1 reset state
    chk(irq == 0, "R1", "irq after reset", {31'h0, irq}, 0);
    chk(matchOut == 0, "R1", "matchOut after reset", {28'h0, matchOut}, 0);
    busRd(7'h08, v); chk(v == 0, "R1", "counter after reset", v, 0);
    busRd(7'h14, v); chk(v == 0, "R1", "match ctl after reset", v, 0);

    // R2 map, R10 read-only capture
    busWr(7'h20, 32'hDEADBEEF);
    busRd(7'h20, v); chk(v == 32'hDEADBEEF, "R2", "match value 2 readback", v, 32'hDEADBEEF);
    busWr(7'h50, 32'h12345678);
    busRd(7'h50, v); chk(v == 0, "R2", "unmapped offset", v, 0);
    busWr(7'h30, 32'h00001234);
    busRd(7'h30, v); chk(v == 0, "R10", "capture 1 after write", v, 0);

    // R5 periodic flag every N clocks
    busWr(7'h04, 32'h2);
    busWr(7'h00, 32'hFF);
    busWr(7'h0C, 0);
    busWr(7'h18, 5);
    busWr(7'h14, 32'h3);
    busWr(7'h04, 32'h1);
    while (!irq) @(negedge clk);
    t0 = cyc;
    busWr(7'h00, 32'h1);
    while (!irq) @(negedge clk);
    t1 = cyc;
    chk(t1 - t0 == 5, "R5", "period with match 5", t1 - t0, 5);
    busWr(7'h00, 32'h1);
    while (!irq) @(negedge clk);
    chk(cyc - t1 == 5, "R5", "second period", cyc - t1, 5);

    // R5 stop on channel 1
    busWr(7'h04, 32'h2);
    busWr(7'h00, 32'hFF);
    busWr(7'h1C, 3);
    busWr(7'h14, 32'h20);
    busWr(7'h04, 32'h1);
    idle(10);
    busRd(7'h04, v); chk(v == 0, "R5", "enable after stop", v, 0);
    busRd(7'h08, v); chk(v == 3, "R5", "counter at stop", v, 3);

    // R4 prescale
    busWr(7'h04, 32'h2);
    busWr(7'h14, 0);
    busWr(7'h0C, 3);
    busWr(7'h04, 32'h1);
    idle(40);
    busRd(7'h08, v); chk(v == 10, "R4", "count after 40 clocks prescale 3", v, 10);
    busWr(7'h04, 0);
    busRd(7'h08, v);
    idle(10);
    busRd(7'h08, v2); chk(v == 10 && v2 == 10, "R4", "frozen when disabled", v2, 10);

    // R3 hold
    busWr(7'h04, 32'h3);
    idle(5);
    busRd(7'h08, v); chk(v == 0, "R3", "counter under hold", v, 0);
    busRd(7'h10, v); chk(v == 0, "R3", "prescale counter under hold", v, 0);

    // R6 match outputs
    busWr(7'h04, 32'h2);
    busWr(7'h0C, 0);
    busWr(7'h18, 2);
    busWr(7'h1C, 3);
    busWr(7'h20, 4);
    busWr(7'h3C, (2 << 4) | (3 << 6) | (1 << 8) | 4);
    chk(matchOut == 4'b0100, "R6", "output written", {28'h0, matchOut}, 4);
    busWr(7'h04, 32'h1);
    idle(10);
    chk(matchOut == 4'b0011, "R6", "outputs after matches", {28'h0, matchOut}, 3);

    // R8 clear racing a hardware set
    busWr(7'h04, 32'h2);
    busWr(7'h00, 32'hFF);
    busWr(7'h18, 3);
    busWr(7'h14, 32'h3);
    busWr(7'h04, 32'h1);
    @(negedge clk);
    sel = 1; wr = 1; addr = 7'h00; wdata = 32'h1;
    highs = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #5;
      if (irq) highs++;
    end
    sel = 0; wr = 0;
    chk(highs >= 5, "R8", "flags survive simultaneous clear", highs, 5);
    busWr(7'h14, 0);
    busWr(7'h00, 32'hFF);
    busRd(7'h00, v); chk(v == 0, "R8", "flags after clear", v, 0);
    chk(irq == 0, "R8", "irq after clear", {31'h0, irq}, 0);

    // R7 capture
    busWr(7'h28, 32'h15);
    capPin[0] = 1;
    idle(6);
    busRd(7'h00, v); chk(v == 32'h10, "R7", "capture 0 flag", v, 32'h10);
    capPin[1] = 1; idle(4); capPin[1] = 0; idle(6);
    busRd(7'h00, v); chk(v == 32'h10, "R7", "no flag without enable", v, 32'h10);
    busRd(7'h30, v); chk(v == mCap[1] && v != 0, "R7", "capture 1 loaded", v, mCap[1]);
    busWr(7'h00, 32'h10);
    busWr(7'h28, 0);
    capPin[0] = 0;

    // R9 edge counting on pin 2
    busWr(7'h04, 32'h2);
    busWr(7'h70, 32'h9);
    busWr(7'h04, 32'h1);
    for (int i = 0; i < 3; i++) begin
      capPin[2] = 1; idle(3);
      capPin[2] = 0; idle(3);
    end
    idle(5);
    busRd(7'h08, v); chk(v == 3, "R9", "rising edges counted", v, 3);
    busWr(7'h70, 32'hB);
    capPin[2] = 1; idle(4); capPin[2] = 0; idle(5);
    busRd(7'h08, v); chk(v == 5, "R9", "both edges counted", v, 5);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule